// File: doc/BRIEF.md
# Debug-State Exception Status Tracker

This block runs next to a processor core's exception logic and decides what happens to exceptions that are raised while the core is halted for a debugger. Inside debug state the core does not change mode or program counter. Each exception either vanishes or becomes a sticky flag in a 32-bit debug status word. A precise data abort also loads the fault status and fault address registers, exactly as it would outside debug state.

Imprecise data aborts are handled in two ways, depending on when they arrive. An abort that arrives while the core is already halted is flagged and then thrown away. An abort that the implicit memory barrier detects during the entry sequence is held as pending, together with its type. A single-cycle take pulse then hands it back to the core when debug state is left.

The block does not model the pipeline, the register banks or the exception entry sequence. Their effect is only visible on the `suppress` and `take_iabt` outputs. A debugger clears the sticky flags through a write-one-to-clear port.

Top module: `dbg_exc_tracker`

## Requirements
- R1: A synchronous active-low reset sets `dsr`, `fsr`, `far`, `take_iabt`, `take_type` and the pending entry abort to zero.
- R2: A supervisor call or secure monitor call event while `in_debug` is high changes no status bit, loads no fault register and causes no take pulse.
- R3: An undefined instruction event while `in_debug` is high sets `dsr[8]` from the next cycle on.
- R4: A precise abort while `in_debug` is high sets `dsr[6]` and, in the next cycle, shows its fault status on `fsr` and its address on `far`.
- R5: An imprecise abort while `in_debug` is high and `dbg_enter` is low sets `dsr[7]`, leaves `fsr` and `far` unchanged, and produces no take pulse at the later exit.
- R6: An imprecise abort in the cycle of `dbg_enter` is held as pending and does not set `dsr[7]`. The next `dbg_exit` raises `take_iabt` for exactly one cycle, in the cycle after the strobe, with the latched type on `take_type`. The pending abort is then cleared, so a later exit gives no pulse. If several entry aborts are latched, the most recent type is kept.
- R7: Bits 8, 7 and 6 of `dsr` stay set until a cycle with `clr_en` high writes a one to the same position of `clr_data`. A set and a clear in the same cycle leave the bit set. All other bits of `dsr` read zero.
- R8: Events that arrive in the same cycle each set their own sticky bit. `fsr` and `far` take their values only from the precise abort.
- R9: While `in_debug` is low, events other than an imprecise abort in the `dbg_enter` cycle change nothing: no sticky bit, no fault register and no pending abort.
- R10: `suppress` is high, in the same cycle and without a clock edge, exactly when `in_debug` is high and at least one of the five exception events is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_debug | input | 1 | Core is halted in debug state |
| dbg_enter | input | 1 | One-cycle strobe: entry sequence (with its barrier) runs this cycle |
| dbg_exit | input | 1 | One-cycle strobe: core leaves debug state |
| ev_svc | input | 1 | Supervisor call event |
| ev_smc | input | 1 | Secure monitor call event |
| ev_undef | input | 1 | Undefined instruction event |
| ev_pabt | input | 1 | Precise data abort event |
| pabt_fs | input | FS_W | Fault status of the precise abort |
| pabt_addr | input | ADDR_W | Faulting address of the precise abort |
| ev_iabt | input | 1 | Imprecise data abort event |
| iabt_type | input | TYPE_W | Type code of the imprecise abort |
| clr_en | input | 1 | Write strobe of the clear port |
| clr_data | input | 32 | Write-one-to-clear data, aligned with `dsr` |
| dsr | output | 32 | Debug status word, sticky bits at 6, 7 and 8 |
| fsr | output | FS_W | Fault status register |
| far | output | ADDR_W | Fault address register |
| suppress | output | 1 | Exception in this cycle is absorbed by debug state |
| take_iabt | output | 1 | One-cycle pulse: take the latched entry abort |
| take_type | output | TYPE_W | Type of the abort being taken |

## Verification
The bound checker checks several rules on every cycle. It checks that each qualified event sets its sticky bit in the next cycle, and that a set bit holds until it is cleared. It checks that a precise abort loads both fault registers, and that a precise abort outside debug state leaves them alone. It also checks that a take pulse lasts one cycle and always follows an exit strobe. Other behaviours span a whole entry-to-exit episode, so only the bench's scenarios can show them: an abort seen at entry being taken at exit, an in-debug abort being dropped, set winning over clear, and the supervisor and monitor calls leaving the state untouched.

// File: rtl/dbgx_pkg.sv
// Package dbgx_pkg: positions and indices shared by the tracker and its checker.
// Assumes the status word is 32 bits and the three sticky flags are adjacent.
package dbgx_pkg;
    localparam int STAT_W      = 32;
    localparam int N_STICKY    = 3;
    localparam int STICKY_BASE = 6;            // lowest sticky bit in the status word
    localparam int IDX_PABT    = 0;            // status bit 6
    localparam int IDX_IABT    = 1;            // status bit 7
    localparam int IDX_UNDEF   = 2;            // status bit 8
    localparam int POS_PABT    = STICKY_BASE + IDX_PABT;
    localparam int POS_IABT    = STICKY_BASE + IDX_IABT;
    localparam int POS_UNDEF   = STICKY_BASE + IDX_UNDEF;
endpackage

// File: rtl/sticky_bank.sv
// Module sticky_bank: N independent sticky flags with write-one-to-clear.
// A set request in the same cycle as a clear request wins.
// Assumes set_i and clr_i are already qualified by the caller.
module sticky_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold one flag: reset, set-priority update, clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/fault_capture.sv
// Module fault_capture: fault status and fault address registers.
// Loads both on a qualified precise abort and holds them otherwise.
// Assumes load_i is high for one cycle for each abort.
module fault_capture #(
    parameter int FS_W   = 5,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FS_W-1:0]   fs_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [FS_W-1:0]   fsr_o,
    output logic [ADDR_W-1:0] far_o
);
    // Capture the abort's status and address together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_o <= '0;
            far_o <= '0;
        end else if (load_i) begin
            fsr_o <= fs_i;
            far_o <= addr_i;
        end
    end
endmodule

// File: rtl/entry_abort_latch.sv
// Module entry_abort_latch: holds an imprecise abort found by the entry barrier
// and hands it back as a one-cycle take pulse when the exit strobe comes.
// Assumes the entry and exit strobes never fall in the same cycle.
module entry_abort_latch #(
    parameter int TYPE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              exit_i,
    input  logic              iabt_i,
    input  logic [TYPE_W-1:0] type_i,
    output logic              take_o,
    output logic [TYPE_W-1:0] take_type_o
);
    logic              pend_q;
    logic [TYPE_W-1:0] ptype_q;
    logic              fire;

    // Pulse condition: leaving debug state with an abort held.
    always_comb fire = exit_i && pend_q;

    // Pending flag and type: latch at entry, drop at exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            ptype_q <= '0;
        end else if (enter_i && iabt_i) begin
            pend_q  <= 1'b1;
            ptype_q <= type_i;
        end else if (exit_i) begin
            pend_q  <= 1'b0;
        end
    end

    // Take pulse and the type that goes with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o      <= 1'b0;
            take_type_o <= '0;
        end else begin
            take_o <= fire;
            if (fire)
                take_type_o <= ptype_q;
        end
    end
endmodule

// File: rtl/dbg_exc_tracker.sv
// Module dbg_exc_tracker: top level. Qualifies the exception events with the
// debug-state flag and the entry strobe, then drives the sticky bank, the fault
// registers and the entry-abort latch.
// Assumes in_debug is high from the cycle after dbg_enter up to and including
// the dbg_exit cycle.
module dbg_exc_tracker
    import dbgx_pkg::*;
#(
    parameter int FS_W   = 5,
    parameter int ADDR_W = 32,
    parameter int TYPE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_debug,
    input  logic              dbg_enter,
    input  logic              dbg_exit,
    input  logic              ev_svc,
    input  logic              ev_smc,
    input  logic              ev_undef,
    input  logic              ev_pabt,
    input  logic [FS_W-1:0]   pabt_fs,
    input  logic [ADDR_W-1:0] pabt_addr,
    input  logic              ev_iabt,
    input  logic [TYPE_W-1:0] iabt_type,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] dsr,
    output logic [FS_W-1:0]   fsr,
    output logic [ADDR_W-1:0] far,
    output logic              suppress,
    output logic              take_iabt,
    output logic [TYPE_W-1:0] take_type
);
    logic [N_STICKY-1:0] set_v;
    logic [N_STICKY-1:0] clr_v;
    logic [N_STICKY-1:0] flag_v;

    // Qualify events: only debug state makes a sticky flag; entry-cycle aborts go to the latch.
    always_comb begin
        set_v            = '0;
        set_v[IDX_PABT]  = in_debug && ev_pabt;
        set_v[IDX_IABT]  = in_debug && ev_iabt && !dbg_enter;
        set_v[IDX_UNDEF] = in_debug && ev_undef;
    end

    // Map the clear-port bits onto the sticky flags.
    for (genvar i = 0; i < N_STICKY; i++) begin : g_clr
        assign clr_v[i] = clr_en && clr_data[STICKY_BASE+i];
    end

    // Absorb indicator: any exception seen while halted.
    always_comb suppress = in_debug && (ev_svc || ev_smc || ev_undef || ev_pabt || ev_iabt);

    // Build the status word with the flags at their fixed positions.
    always_comb begin
        dsr = '0;
        for (int i = 0; i < N_STICKY; i++)
            dsr[STICKY_BASE+i] = flag_v[i];
    end

    sticky_bank #(.N(N_STICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (flag_v)
    );

    fault_capture #(.FS_W(FS_W), .ADDR_W(ADDR_W)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (set_v[IDX_PABT]),
        .fs_i   (pabt_fs),
        .addr_i (pabt_addr),
        .fsr_o  (fsr),
        .far_o  (far)
    );

    entry_abort_latch #(.TYPE_W(TYPE_W)) u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (dbg_enter),
        .exit_i      (dbg_exit),
        .iabt_i      (ev_iabt),
        .type_i      (iabt_type),
        .take_o      (take_iabt),
        .take_type_o (take_type)
    );
endmodule

// File: rtl/dbg_exc_tracker_chk.sv
// Module dbg_exc_tracker_chk: temporal checks on the tracker's ports, bound to the top.
module dbg_exc_tracker_chk
    import dbgx_pkg::*;
#(
    parameter int FS_W   = 5,
    parameter int ADDR_W = 32,
    parameter int TYPE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_debug,
    input logic              dbg_enter,
    input logic              dbg_exit,
    input logic              ev_svc,
    input logic              ev_smc,
    input logic              ev_undef,
    input logic              ev_pabt,
    input logic [FS_W-1:0]   pabt_fs,
    input logic [ADDR_W-1:0] pabt_addr,
    input logic              ev_iabt,
    input logic [TYPE_W-1:0] iabt_type,
    input logic              clr_en,
    input logic [STAT_W-1:0] clr_data,
    input logic [STAT_W-1:0] dsr,
    input logic [FS_W-1:0]   fsr,
    input logic [ADDR_W-1:0] far,
    input logic              suppress,
    input logic              take_iabt,
    input logic [TYPE_W-1:0] take_type
);
    assert_undef_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_debug && ev_undef) |=> dsr[POS_UNDEF]);

    assert_pabt_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_debug && ev_pabt) |=> (dsr[POS_PABT] && fsr == $past(pabt_fs) && far == $past(pabt_addr)));

    assert_iabt_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_debug && ev_iabt && !dbg_enter) |=> dsr[POS_IABT]);

    assert_take_after_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_iabt |-> $past(dbg_exit));

    assert_take_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_iabt |=> !take_iabt);

    assert_undef_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dsr[POS_UNDEF] && !(clr_en && clr_data[POS_UNDEF])) |=> dsr[POS_UNDEF]);

    assert_outside_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_debug && ev_pabt) |=> ($stable(fsr) && $stable(far)));
endmodule

bind dbg_exc_tracker dbg_exc_tracker_chk #(.FS_W(FS_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_chk (.*);

// File: tb/sim_dbg_exc_tracker.sv
`timescale 1ns/1ps
// Bench for dbg_exc_tracker: directed corner cases plus seeded random traffic,
// compared against a reference model kept in bench variables.
module sim_dbg_exc_tracker;
    localparam int FS_W = 5, ADDR_W = 32, TYPE_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_debug = 0, dbg_enter = 0, dbg_exit = 0;
    logic ev_svc = 0, ev_smc = 0, ev_undef = 0, ev_pabt = 0, ev_iabt = 0;
    logic [FS_W-1:0]   pabt_fs = '0;
    logic [ADDR_W-1:0] pabt_addr = '0;
    logic [TYPE_W-1:0] iabt_type = '0;
    logic clr_en = 0;
    logic [31:0] clr_data = '0;
    logic [31:0] dsr;
    logic [FS_W-1:0] fsr;
    logic [ADDR_W-1:0] far;
    logic suppress, take_iabt;
    logic [TYPE_W-1:0] take_type;

    always #2 clk = ~clk;   // 250 MHz

    dbg_exc_tracker #(.FS_W(FS_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u0 (.*);

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_dsr;
    logic [FS_W-1:0] m_fsr;
    logic [ADDR_W-1:0] m_far;
    logic m_pend, m_take;
    logic [TYPE_W-1:0] m_ptype, m_ttype;
    bit dbg_st = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] status_next(input logic [31:0] old);
        logic [31:0] setm, clrm;
        setm = '0;
        setm[8] = in_debug && ev_undef;
        setm[7] = in_debug && ev_iabt && !dbg_enter;
        setm[6] = in_debug && ev_pabt;
        clrm = clr_en ? (clr_data & 32'h0000_01C0) : 32'h0;
        return (old & ~clrm) | setm;
    endfunction

    function automatic logic exp_suppress();
        return in_debug && (ev_svc || ev_smc || ev_undef || ev_pabt || ev_iabt);
    endfunction

    task automatic idle();
        dbg_enter = 0; dbg_exit = 0; ev_svc = 0; ev_smc = 0; ev_undef = 0;
        ev_pabt = 0; ev_iabt = 0; clr_en = 0; clr_data = '0;
    endtask

    // One cycle: inputs are already driven (after negedge); check, clock, update, compare.
    task automatic cyc();
        #0.5;
        chk("R10 suppress", {63'b0, suppress}, {63'b0, exp_suppress()});
        @(posedge clk);
        if (!rst_n) begin
            m_dsr = '0; m_fsr = '0; m_far = '0; m_pend = 0; m_take = 0; m_ptype = '0; m_ttype = '0;
        end else begin
            m_dsr = status_next(m_dsr);
            if (in_debug && ev_pabt) begin m_fsr = pabt_fs; m_far = pabt_addr; end
            m_take = dbg_exit && m_pend;
            if (m_take) m_ttype = m_ptype;
            if (dbg_enter && ev_iabt) begin m_pend = 1; m_ptype = iabt_type; end
            else if (dbg_exit) m_pend = 0;
        end
        #1;
        chk("R7 dsr", {32'b0, dsr}, {32'b0, m_dsr});
        chk("R4 fsr", {59'b0, fsr}, {59'b0, m_fsr});
        chk("R4 far", {32'b0, far}, {32'b0, m_far});
        chk("R6 take_iabt", {63'b0, take_iabt}, {63'b0, m_take});
        if (m_take) chk("R6 take_type", {62'b0, take_type}, {62'b0, m_ttype});
        @(negedge clk);
        if (dbg_enter) dbg_st = 1;
        if (dbg_exit) dbg_st = 0;
        idle();
        in_debug = dbg_st;
    endtask

    task automatic enter_dbg(input logic with_iabt, input logic [TYPE_W-1:0] t);
        dbg_enter = 1; ev_iabt = with_iabt; iabt_type = t; cyc();
    endtask

    task automatic exit_dbg();
        dbg_exit = 1; cyc();
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle();
        rst_n = 0;
        repeat (3) cyc();
        chk("R1 reset dsr", {32'b0, dsr}, 64'h0);
        chk("R1 reset take", {63'b0, take_iabt}, 64'h0);
        rst_n = 1;
        cyc();

        // R9: events outside debug state do nothing
        ev_undef = 1; ev_pabt = 1; ev_iabt = 1; pabt_fs = 5'h1A; pabt_addr = 32'hDEAD_0000; cyc();
        chk("R9 outside dsr", {32'b0, dsr}, 64'h0);
        chk("R9 outside fsr", {59'b0, fsr}, 64'h0);
        exit_dbg();
        chk("R9 no pending", {63'b0, take_iabt}, 64'h0);

        // R2: supervisor / monitor calls in debug are ignored
        enter_dbg(0, 0);
        ev_svc = 1; ev_smc = 1; cyc();
        chk("R2 svc smc dsr", {32'b0, dsr}, 64'h0);

        // R3 / R8: undef and precise abort together
        ev_undef = 1; ev_pabt = 1; pabt_fs = 5'h0B; pabt_addr = 32'h1234_5678; cyc();
        chk("R3 undef bit8", {63'b0, dsr[8]}, 64'h1);
        chk("R8 both bits", {32'b0, dsr}, 64'h140);
        chk("R4 far load", {32'b0, far}, 64'h1234_5678);

        // R5: in-debug imprecise abort flagged, fault regs untouched, dropped at exit
        ev_iabt = 1; iabt_type = 2'd3; cyc();
        chk("R5 bit7", {63'b0, dsr[7]}, 64'h1);
        chk("R5 fsr kept", {59'b0, fsr}, 64'h0B);
        exit_dbg();
        cyc();
        chk("R5 dropped", {63'b0, take_iabt}, 64'h0);

        // R7: write-one-to-clear, and set beats clear
        clr_en = 1; clr_data = 32'h0000_0080; cyc();
        chk("R7 clear bit7", {32'b0, dsr}, 64'h140);
        in_debug = 1; ev_undef = 1; clr_en = 1; clr_data = 32'hFFFF_FFFF; cyc();
        chk("R7 set wins", {32'b0, dsr}, 64'h100);
        clr_en = 1; clr_data = 32'h0000_0100; cyc();
        chk("R7 cleared", {32'b0, dsr}, 64'h0);

        // R6: entry-time abort taken at exit, once
        enter_dbg(1, 2'd2);
        chk("R6 no bit7 at entry", {63'b0, dsr[7]}, 64'h0);
        repeat (2) cyc();
        dbg_exit = 1; #0.5; @(posedge clk); #1;
        // hand back to cyc-style bookkeeping
        m_take = m_pend; m_ttype = m_ptype; m_pend = 0;
        chk("R6 take pulse", {63'b0, take_iabt}, 64'h1);
        chk("R6 take type", {62'b0, take_type}, 64'h2);
        @(negedge clk); idle(); dbg_st = 0; in_debug = 0;
        cyc();
        chk("R6 single pulse", {63'b0, take_iabt}, 64'h0);
        enter_dbg(0, 0);
        exit_dbg();
        chk("R6 pending cleared", {63'b0, take_iabt}, 64'h0);
        cyc();

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            if (!dbg_st && ($urandom % 8) == 0) dbg_enter = 1;
            else if (dbg_st && ($urandom % 10) == 0) dbg_exit = 1;
            in_debug = dbg_st;
            ev_svc   = ($urandom % 4) == 0;
            ev_smc   = ($urandom % 4) == 0;
            ev_undef = ($urandom % 5) == 0;
            ev_pabt  = ($urandom % 5) == 0;
            ev_iabt  = ($urandom % 4) == 0;
            pabt_fs  = FS_W'($urandom);
            pabt_addr = $urandom;
            iabt_type = TYPE_W'($urandom);
            clr_en   = ($urandom % 6) == 0;
            clr_data = $urandom;
            cyc();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule